// File: doc/BRIEF.md
# SPI Master FIFO Register Front End

This block is the register-mapped side of an SPI master. Software talks to it over a plain 32-bit read/write bus with byte offsets. The block holds a transmit queue and a receive queue of bytes. Each queue reports its state in bit 31 of its data register, so a single read tells software whether it can go on. On the other side, a ready/valid word interface lets the serial frame engine take bytes to send and hand back bytes it has received. The frame engine and all serial timing sit outside this block.

Two programmable level thresholds produce live pending bits. These bits are the current comparison of queue occupancy against the thresholds, not latched events. A two-bit enable register gates the pending bits onto a single interrupt line. The block also holds the idle levels of the chip-select lines. That register implements only as many bits as there are select lines, so writing all ones and reading the value back tells software how many lines exist. A mode bit gives the serial bus to a memory-mapped flash path instead of the queues. It resets to that mode, and software must clear it before the queues can move any data.

Top module: `spi_fifo_regs`

## Requirements
- R1: After reset both queues are empty, the enable register (0x70) reads 0, the transmit threshold (0x50) reads 1, the receive threshold (0x54) reads 0, the flash mode register (0x60) reads 1, the select-default register (0x14) reads all implemented bits set, and `irq` is low.
- R2: A write to 0x48 stores bits [7:0] in the transmit queue. The engine receives the stored bytes on `eng_tx_data` in the order they were written, with `eng_tx_valid` high while the queue is not empty.
- R3: A read of 0x48 returns bit 31 set exactly when the transmit queue holds DEPTH bytes; all other bits read 0.
- R4: A write to 0x48 while the transmit queue is full is discarded: the full flag stays set and the byte never reaches the engine.
- R5: A read of 0x4C from a non-empty receive queue returns the oldest byte in bits [7:0] with bit 31 clear, and removes that byte. A read from an empty queue returns exactly 0x8000_0000 and removes nothing.
- R6: `eng_rx_ready` is high exactly when the receive queue holds fewer than DEPTH bytes. A byte offered while it is low is not stored.
- R7: The pending register (0x74) reads bit 0 = (transmit occupancy < transmit threshold) and bit 1 = (receive occupancy > receive threshold), tracking the levels in the same cycle. Writes to it have no effect.
- R8: The thresholds at 0x50 and 0x54 store the low bits of the written word (enough to hold 0..DEPTH) and read back the stored value.
- R9: The enable register 0x70 stores bits [1:0] (bit 0 transmit, bit 1 receive). `irq` is high exactly when some pending bit and its enable bit are both set.
- R10: The select-default register at 0x14 keeps only NUM_CS bits, drives them on `cs_default`, and reads back zero-extended. Writing all ones therefore reads back NUM_CS ones.
- R11: While bit 0 of 0x60 is 1, `eng_tx_valid` and `eng_rx_ready` are held low and the engine can neither take nor deliver bytes. Writing 0 hands the serial path to the queues.
- R12: A read from any offset not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe (a read of 0x4C removes a byte) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_valid | output | 1 | Transmit byte available |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive queue can accept a byte |
| cs_default | output | NUM_CS | Idle level of each select line |
| flash_mode | output | 1 | Serial path owned by the memory-mapped flash path |
| irq | output | 1 | Enabled pending threshold condition |

## Verification
Read data, pending bits, `irq`, `eng_tx_valid` and `eng_rx_ready` are combinational from the registers. Each of them is therefore due in the same cycle as the strobe or level that produces it, and it moves at the first rising edge after a write, push or pop. Stimulus is applied just after a falling edge and sampled one nanosecond later, before the next rising edge. A read value is captured in the cycle of its strobe, and any effect of a write is sampled only after the rising edge that commits it. The threshold comparisons are swept over every threshold value from 0 to DEPTH against every occupancy from 0 to DEPTH, and the interrupt gating over all sixteen pending/enable pairs.

// File: rtl/sfr_pkg.sv
// Shared constants of the SPI FIFO register front end.
// Assumes byte offsets on an 8-bit register address.
package sfr_pkg;
    localparam int REG_ADDR_W = 8;

    localparam logic [REG_ADDR_W-1:0] OFS_CS_DEFAULT = 8'h14;
    localparam logic [REG_ADDR_W-1:0] OFS_TX_DATA    = 8'h48;
    localparam logic [REG_ADDR_W-1:0] OFS_RX_DATA    = 8'h4C;
    localparam logic [REG_ADDR_W-1:0] OFS_TX_MARK    = 8'h50;
    localparam logic [REG_ADDR_W-1:0] OFS_RX_MARK    = 8'h54;
    localparam logic [REG_ADDR_W-1:0] OFS_FLASH_CTL  = 8'h60;
    localparam logic [REG_ADDR_W-1:0] OFS_IRQ_EN     = 8'h70;
    localparam logic [REG_ADDR_W-1:0] OFS_IRQ_PEND   = 8'h74;

    localparam int PEND_TX = 0;
    localparam int PEND_RX = 1;
    localparam int PEND_W  = 2;
    localparam int FLAG_BIT = 31;
endpackage

// File: rtl/sfr_fifo.sv
// Synchronous first-in first-out byte queue with occupancy count.
// A push while full and a pop while empty are ignored; both may occur
// in one cycle. DEPTH need not be a power of two.
module sfr_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;
    logic             do_push;
    logic             do_pop;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = mem[rptr];

    // Advance a pointer with explicit wrap at DEPTH-1.
    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Store a pushed word.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= next_ptr(wptr);
            if (do_pop)  rptr <= next_ptr(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full); // R4
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty); // R5
    AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> count == $past(count) + CW'(1)); // R2
endmodule

// File: rtl/sfr_mark_irq.sv
// Threshold registers, enable register, live pending bits and the
// interrupt line. Pending bits are pure compares of the current
// occupancies against the thresholds; nothing is latched.
module sfr_mark_irq #(
    parameter int CW = 4,
    localparam int PW = sfr_pkg::PEND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_mark_we,
    input  logic          rx_mark_we,
    input  logic          ie_we,
    input  logic [31:0]   wdata,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    output logic [CW-1:0] tx_mark,
    output logic [CW-1:0] rx_mark,
    output logic [PW-1:0] ie,
    output logic [PW-1:0] ip,
    output logic          irq
);
    // Threshold and enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_mark <= CW'(1);
            rx_mark <= '0;
            ie      <= '0;
        end else begin
            if (tx_mark_we) tx_mark <= wdata[CW-1:0];
            if (rx_mark_we) rx_mark <= wdata[CW-1:0];
            if (ie_we)      ie      <= wdata[PW-1:0];
        end
    end

    // Live level compares.
    always_comb begin
        ip = '0;
        ip[sfr_pkg::PEND_TX] = (tx_count < tx_mark);
        ip[sfr_pkg::PEND_RX] = (rx_count > rx_mark);
    end

    // Enabled pending sources drive the interrupt.
    assign irq = |(ip & ie);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq); // R9
    AST_TX_PEND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0 && tx_mark != '0) |-> ip[sfr_pkg::PEND_TX]); // R7
    AST_RX_PEND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !ip[sfr_pkg::PEND_RX]); // R7
endmodule

// File: rtl/sfr_cs_lines.sv
// Idle-level register of the chip-select lines. Only NUM_CS bits
// exist, so software can count lines by writing ones and reading back.
// Resets with every line idle high.
module sfr_cs_lines #(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [NUM_CS-1:0] wdata,
    output logic [NUM_CS-1:0] lines
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        // One flop per implemented select line.
        always_ff @(posedge clk) begin
            if (!rst_n)  lines[g] <= 1'b1;
            else if (we) lines[g] <= wdata[g];
        end
    end
endmodule

// File: rtl/spi_fifo_regs.sv
// Register front end of an SPI master: byte queues toward the frame
// engine, status in bit 31 of the data registers, threshold interrupts,
// select-line idle levels and the flash-path ownership bit.
// Assumes WIDTH <= 31 and NUM_CS <= 32. Read data is combinational.
module spi_fifo_regs #(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 8,
    parameter int NUM_CS = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = sfr_pkg::REG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [WIDTH-1:0]  eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_tx_ready,
    input  logic [WIDTH-1:0]  eng_rx_data,
    input  logic              eng_rx_valid,
    output logic              eng_rx_ready,
    output logic [NUM_CS-1:0] cs_default,
    output logic              flash_mode,
    output logic              irq
);
    import sfr_pkg::*;

    logic             tx_wr, rx_rd;
    logic             tx_pop, rx_push, rx_pop;
    logic [CW-1:0]    tx_count, rx_count;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [WIDTH-1:0] rx_head;
    logic [CW-1:0]    tx_mark, rx_mark;
    logic [PEND_W-1:0] ie, ip;

    // Decode of the strobes that move queue data.
    assign tx_wr   = bus_wr_en && (bus_addr == OFS_TX_DATA);
    assign rx_rd   = bus_rd_en && (bus_addr == OFS_RX_DATA);
    assign rx_pop  = rx_rd && !rx_empty;

    // Engine side, gated while the flash path owns the bus.
    assign eng_tx_valid = !flash_mode && !tx_empty;
    assign tx_pop       = eng_tx_valid && eng_tx_ready;
    assign eng_rx_ready = !flash_mode && !rx_full;
    assign rx_push      = eng_rx_valid && eng_rx_ready;

    sfr_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr), .push_data(bus_wdata[WIDTH-1:0]),
        .pop(tx_pop), .pop_data(eng_tx_data),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    sfr_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(eng_rx_data),
        .pop(rx_pop), .pop_data(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    sfr_mark_irq #(.CW(CW)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_mark_we(bus_wr_en && bus_addr == OFS_TX_MARK),
        .rx_mark_we(bus_wr_en && bus_addr == OFS_RX_MARK),
        .ie_we(bus_wr_en && bus_addr == OFS_IRQ_EN),
        .wdata(bus_wdata),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_mark(tx_mark), .rx_mark(rx_mark),
        .ie(ie), .ip(ip), .irq(irq)
    );

    sfr_cs_lines #(.NUM_CS(NUM_CS)) u_cs (
        .clk(clk), .rst_n(rst_n),
        .we(bus_wr_en && bus_addr == OFS_CS_DEFAULT),
        .wdata(bus_wdata[NUM_CS-1:0]),
        .lines(cs_default)
    );

    // Flash-path ownership bit, owned by flash out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flash_mode <= 1'b1;
        else if (bus_wr_en && bus_addr == OFS_FLASH_CTL)
            flash_mode <= bus_wdata[0];
    end

    // Read-data selection by offset.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_TX_DATA:    bus_rdata[FLAG_BIT] = tx_full;
            OFS_RX_DATA: begin
                if (rx_empty) bus_rdata[FLAG_BIT] = 1'b1;
                else          bus_rdata = 32'(rx_head);
            end
            OFS_TX_MARK:    bus_rdata = 32'(tx_mark);
            OFS_RX_MARK:    bus_rdata = 32'(rx_mark);
            OFS_IRQ_EN:     bus_rdata = 32'(ie);
            OFS_IRQ_PEND:   bus_rdata = 32'(ip);
            OFS_CS_DEFAULT: bus_rdata = 32'(cs_default);
            OFS_FLASH_CTL:  bus_rdata = 32'(flash_mode);
            default:        bus_rdata = '0;
        endcase
    end

    AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full && !tx_pop) |=> tx_full); // R4
    AST_RX_READ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_empty && !rx_push) |=> rx_count == $past(rx_count) - CW'(1)); // R5
    AST_FLASH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_mode && !tx_wr) |=> tx_count == $past(tx_count)); // R11
    AST_RX_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_rd) |=> rx_full); // R6
endmodule

// File: tb/sim_spi_fifo_regs.sv
// Self-checking bench: sweeps thresholds against occupancies and
// checks queue order, flags, gating and reset values.
module sim_spi_fifo_regs;
    localparam int DEPTH  = 8;
    localparam int NUM_CS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_valid;
    logic        eng_tx_ready = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        eng_rx_valid = 1'b0;
    logic        eng_rx_ready;
    logic [NUM_CS-1:0] cs_default;
    logic        flash_mode;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_fifo_regs #(.DEPTH(DEPTH), .WIDTH(8), .NUM_CS(NUM_CS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_tx_ready(eng_tx_ready),
        .eng_rx_data(eng_rx_data), .eng_rx_valid(eng_rx_valid),
        .eng_rx_ready(eng_rx_ready),
        .cs_default(cs_default), .flash_mode(flash_mode), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd_en = 1'b0;
        #1;
    endtask

    task automatic eng_take(output logic v, output logic [7:0] d);
        @(negedge clk);
        eng_tx_ready = 1'b1;
        #1 v = eng_tx_valid; d = eng_tx_data;
        @(negedge clk);
        eng_tx_ready = 1'b0;
        #1;
    endtask

    task automatic eng_give(input logic [7:0] d, output logic rdy);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        #1 rdy = eng_rx_ready;
        @(negedge clk);
        eng_rx_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic v, rdy;
        logic [7:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        bus_read(8'h70, r); chk("R1 ie", r, 0);
        bus_read(8'h50, r); chk("R1 txmark", r, 1);
        bus_read(8'h54, r); chk("R1 rxmark", r, 0);
        bus_read(8'h60, r); chk("R1 flash", r, 1);
        bus_read(8'h14, r); chk("R1 csdef", r, 32'hF);
        bus_read(8'h74, r); chk("R1 pend", r, 1);
        bus_read(8'h4C, r); chk("R1 rx empty", r, 32'h8000_0000);
        bus_read(8'h48, r); chk("R1 tx not full", r, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R11 flash ownership gates the engine side
        bus_write(8'h48, 32'hA5);
        chk("R11 tx_valid gated", {31'b0, eng_tx_valid}, 0);
        chk("R11 rx_ready gated", {31'b0, eng_rx_ready}, 0);
        bus_write(8'h60, 0);
        chk("R11 tx_valid open", {31'b0, eng_tx_valid}, 1);
        chk("R11 rx_ready open", {31'b0, eng_rx_ready}, 1);
        eng_take(v, d); chk("R11 held byte", {23'b0, v, d}, {23'b0, 1'b1, 8'hA5});
        chk("R11 drained", {31'b0, eng_tx_valid}, 0);

        // R10 select-line count
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h14, r); chk("R10 ones", r, 32'hF);
        bus_write(8'h14, 32'hFFFF_FFF5);
        bus_read(8'h14, r); chk("R10 pattern", r, 32'h5);
        chk("R10 port", 32'(cs_default), 32'h5);

        // R2 R3 R4 R7 R8 transmit sweep
        for (int m = 0; m <= DEPTH; m++) begin
            bus_write(8'h50, 32'hFFFF_FFF0 | m);
            bus_read(8'h50, r); chk("R8 txmark", r, m);
            for (int k = 0; k <= DEPTH; k++) begin
                bus_read(8'h74, r); chk("R7 tx pend", r, (k < m) ? 1 : 0);
                bus_read(8'h48, r); chk("R3 full flag", r, (k == DEPTH) ? 32'h8000_0000 : 0);
                if (k < DEPTH) bus_write(8'h48, 32'hABCD_0000 | (m * 16 + k));
            end
            bus_write(8'h48, 32'hEE);
            bus_read(8'h48, r); chk("R4 still full", r, 32'h8000_0000);
            for (int k = 0; k < DEPTH; k++) begin
                eng_take(v, d);
                chk("R2 order", {23'b0, v, d}, {23'b0, 1'b1, 8'(m * 16 + k)});
            end
            chk("R4 dropped byte absent", {31'b0, eng_tx_valid}, 0);
        end

        // R5 R6 R7 R8 receive sweep
        bus_write(8'h50, 0);
        for (int m = 0; m <= DEPTH; m++) begin
            bus_write(8'h54, m);
            bus_read(8'h54, r); chk("R8 rxmark", r, m);
            for (int k = 0; k <= DEPTH; k++) begin
                bus_read(8'h74, r); chk("R7 rx pend", r, (k > m) ? 2 : 0);
                eng_give(8'((m * 16 + k) ^ 8'h5A), rdy);
                chk("R6 ready", {31'b0, rdy}, (k < DEPTH) ? 1 : 0);
            end
            for (int k = 0; k < DEPTH; k++) begin
                bus_read(8'h4C, r); chk("R5 data", r, 32'(8'((m * 16 + k) ^ 8'h5A)));
            end
            bus_read(8'h4C, r); chk("R5 empty", r, 32'h8000_0000);
        end
        eng_give(8'h3C, rdy);
        bus_read(8'h4C, r); chk("R5 no pop on empty", r, 32'h3C);
        bus_read(8'h4C, r); chk("R5 empty again", r, 32'h8000_0000);

        // R9 interrupt gating over all pending/enable pairs
        eng_give(8'h11, rdy);
        for (int p = 0; p < 4; p++) begin
            bus_write(8'h50, (p & 1) ? 1 : 0);
            bus_write(8'h54, (p & 2) ? 0 : 1);
            bus_read(8'h74, r); chk("R7 pend combo", r, p);
            for (int e = 0; e < 4; e++) begin
                bus_write(8'h70, 32'hFFFF_FFFC | e);
                bus_read(8'h70, r); chk("R9 ie", r, e);
                chk("R9 irq", {31'b0, irq}, ((p & e) != 0) ? 1 : 0);
            end
        end
        bus_write(8'h74, 0);
        bus_read(8'h74, r); chk("R7 write ignored", r, 3);

        // R12 unmapped offset
        bus_read(8'h08, r); chk("R12 unmapped", r, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule